// File: doc/BRIEF.md
# Synchronized Four-Channel DAC Register Bank

This block keeps the output codes and output ranges for four 12-bit digital-to-analog channels and presents them to external converters. Software reaches it through a small byte-addressed register bus: one 16-bit word per channel for the code, a shared 8-bit register that packs a 2-bit range select for every channel, a control register that chooses between immediate and synchronized update, and a strobe address.

In immediate mode a code written to a channel shows on that channel's output after the next clock edge. In synchronized mode each code write only fills a per-channel staging register. A later write to the strobe address moves all four staged codes to the outputs on the same edge, so the converters change together. Range changes bypass staging in both modes. The register bus has a combinational read path that returns the range register, the mode bit and the staged codes.

Top module: `dacbank_regs`

## Requirements
- R1: While `rst` is high and after it falls, the bank holds synchronized mode on, range register 0xAA (every channel ±5 V), and every staged and output code at 0x800 (midscale).
- R2: A write to byte offset 2×c (c = 0..3) stores `wdata[11:0]` as channel c's staged code; `wdata[15:12]` is discarded. A read at 2×c returns that staged code with bits 15:12 zero.
- R3: With synchronized mode off, a code write to channel c appears on `code_o[12c+11:12c]` after the next rising clock edge, and the other channels keep their codes.
- R4: With synchronized mode on, code writes leave `code_o` unchanged. A write of any value to offset 9 copies all four staged codes to `code_o` on the next rising edge.
- R5: With synchronized mode off, a write to offset 9 leaves `code_o` and `range_o` unchanged.
- R6: A write to offset 8 loads `wdata[7:0]` into the range register. Bits 2c+1:2c select channel c's range (0: 0..5 V, 1: 0..10 V, 2: ±5 V, 3: ±10 V). The register drives `range_o` after the next edge in either mode and reads back at offset 8 with bits 15:8 zero.
- R7: Offset 15 bit 0 is the synchronized-mode enable. A write loads `wdata[0]`, and a read returns it in bit 0 with all other bits zero.
- R8: Writes to offsets 1, 3, 5, 7 and 10..14 change neither `code_o`, `range_o`, the mode bit nor any staged code. Reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| code_o | output | 48 | Four 12-bit output codes, channel c in bits 12c+11:12c |
| range_o | output | 8 | Four 2-bit range selects, channel c in bits 2c+1:2c |

## Verification
Every register effect of a write lands on the rising edge that samples `wr_en`. The bench drives each write on a falling edge and compares `code_o` and `range_o` on the following falling edge, one register stage later. That also makes non-effects visible: a staged write in synchronized mode, a strobe in immediate mode, or an unused offset must leave the outputs exactly as they were at that point. `rdata` has no register in its path, so reads are checked one time unit after the address is applied, with `wr_en` low.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    localparam int NUM_CH    = 4;
    localparam int CODE_W    = 12;
    localparam int BUS_W     = 16;
    localparam int ADDR_W    = 4;
    localparam int RANGE_W   = 2;
    localparam int RNG_REG_W = NUM_CH * RANGE_W;

    localparam logic [ADDR_W-1:0]    OFS_RANGE  = 4'd8;
    localparam logic [ADDR_W-1:0]    OFS_STROBE = 4'd9;
    localparam logic [ADDR_W-1:0]    OFS_SYNC   = 4'd15;

    localparam logic [CODE_W-1:0]    CODE_MID   = 12'h800;
    localparam logic [RNG_REG_W-1:0] RANGE_RST  = 8'hAA;
    localparam logic                 SYNC_RST   = 1'b1;

    typedef enum logic [RANGE_W-1:0] {
        RNG_UNI_5V  = 2'd0,
        RNG_UNI_10V = 2'd1,
        RNG_BIP_5V  = 2'd2,
        RNG_BIP_10V = 2'd3
    } range_sel_e;

    // configuration state shared by the whole bank
    typedef struct packed {
        logic                 sync_en;
        logic [RNG_REG_W-1:0] ranges;
    } bank_cfg_t;

    // one-cycle write enables produced by the address decoder
    typedef struct packed {
        logic range_we;
        logic strobe_we;
        logic sync_we;
    } cfg_wr_t;

    function automatic logic [ADDR_W-1:0] chan_offset(input int ch);
        return ADDR_W'(2 * ch);
    endfunction

    function automatic range_sel_e range_of(input logic [RNG_REG_W-1:0] r,
                                            input int ch);
        return range_sel_e'(r[ch*RANGE_W +: RANGE_W]);
    endfunction

endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
    import dacbank_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int AW    = ADDR_W
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output logic [N_CH-1:0] data_we,
    output cfg_wr_t       cfg_we
);

    for (genvar c = 0; c < N_CH; c++) begin : g_data
        assign data_we[c] = wr_en && (addr == chan_offset(c));
    end

    always_comb begin
        cfg_we           = '0;
        cfg_we.range_we  = wr_en && (addr == OFS_RANGE);
        cfg_we.strobe_we = wr_en && (addr == OFS_STROBE);
        cfg_we.sync_we   = wr_en && (addr == OFS_SYNC);
    end

endmodule

// File: rtl/dacbank_cfg.sv
module dacbank_cfg
    import dacbank_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_wr_t       cfg_we,
    input  logic [DW-1:0] wdata,
    output bank_cfg_t     cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.sync_en <= SYNC_RST;
            cfg_q.ranges  <= RANGE_RST;
        end else begin
            if (cfg_we.sync_we)
                cfg_q.sync_en <= wdata[0];
            if (cfg_we.range_we)
                cfg_q.ranges  <= wdata[RNG_REG_W-1:0];
        end
    end

endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
    import dacbank_pkg::*;
#(
    parameter int              CW       = CODE_W,
    parameter int              DW       = BUS_W,
    parameter logic [CW-1:0]   RST_CODE = CODE_MID
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          data_we,
    input  logic [DW-1:0] wdata,
    input  logic          sync_en,
    input  logic          load_all,
    output logic [CW-1:0] stage_q,
    output logic [CW-1:0] out_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= RST_CODE;
            out_q   <= RST_CODE;
        end else begin
            if (data_we)
                stage_q <= wdata[CW-1:0];
            if (!sync_en && data_we)
                out_q <= wdata[CW-1:0];
            else if (sync_en && load_all)
                out_q <= stage_q;
        end
    end

endmodule

// File: rtl/dacbank_regs.sv
module dacbank_regs
    import dacbank_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int CW   = CODE_W,
    parameter int DW   = BUS_W,
    parameter int AW   = ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic [N_CH*CW-1:0] code_o,
    output logic [RNG_REG_W-1:0] range_o
);

    localparam int PAD_CODE = DW - CW;
    localparam int PAD_RNG  = DW - RNG_REG_W;

    logic [N_CH-1:0]    data_we;
    cfg_wr_t            cfg_we;
    bank_cfg_t          cfg_q;
    logic               sync_q;
    logic [N_CH*CW-1:0] stage_vec;

    dacbank_decode #(.N_CH(N_CH), .AW(AW)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .data_we (data_we),
        .cfg_we  (cfg_we)
    );

    dacbank_cfg #(.DW(DW)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_we (cfg_we),
        .wdata  (wdata),
        .cfg_q  (cfg_q)
    );

    assign sync_q  = cfg_q.sync_en;
    assign range_o = cfg_q.ranges;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dacbank_chan #(.CW(CW), .DW(DW), .RST_CODE(CODE_MID)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .data_we  (data_we[c]),
            .wdata    (wdata),
            .sync_en  (sync_q),
            .load_all (cfg_we.strobe_we),
            .stage_q  (stage_vec[c*CW +: CW]),
            .out_q    (code_o[c*CW +: CW])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_RANGE)
            rdata = {{PAD_RNG{1'b0}}, cfg_q.ranges};
        else if (addr == OFS_SYNC)
            rdata = {{(DW-1){1'b0}}, cfg_q.sync_en};
        else begin
            for (int c = 0; c < N_CH; c++) begin
                if (addr == chan_offset(c))
                    rdata = {{PAD_CODE{1'b0}}, stage_vec[c*CW +: CW]};
            end
        end
    end

endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk
    import dacbank_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int CW   = CODE_W,
    parameter int DW   = BUS_W,
    parameter int AW   = ADDR_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [AW-1:0]        addr,
    input logic [DW-1:0]        wdata,
    input logic                 sync_q,
    input logic [N_CH*CW-1:0]   code_o,
    input logic [RNG_REG_W-1:0] range_o
);

    logic unused_ofs;
    assign unused_ofs = addr[0] ? (addr != OFS_STROBE && addr != OFS_SYNC)
                                : (addr >= AW'(2 * N_CH) && addr != OFS_RANGE);

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (range_o == RANGE_RST && code_o == {N_CH{CODE_MID}} && sync_q));

    for (genvar c = 0; c < N_CH; c++) begin : g_imm
        p_imm_update_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !sync_q && addr == chan_offset(c))
            |=> code_o[c*CW +: CW] == $past(wdata[CW-1:0]));
    end

    p_sync_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (sync_q && !(wr_en && addr == OFS_STROBE)) |=> $stable(code_o));

    p_strobe_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (!sync_q && wr_en && addr == OFS_STROBE) |=> $stable(code_o));

    p_range_load_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_RANGE) |=> range_o == $past(wdata[RNG_REG_W-1:0]));

    p_sync_load_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_SYNC) |=> sync_q == $past(wdata[0]));

    p_unused_ofs_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && unused_ofs) |=> ($stable(code_o) && $stable(range_o) && $stable(sync_q)));

endmodule

bind dacbank_regs dacbank_chk #(.N_CH(N_CH), .CW(CW), .DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .sync_q  (sync_q),
    .code_o  (code_o),
    .range_o (range_o)
);

// File: tb/sim_dacbank_regs.sv
`timescale 1ns/1ps
module sim_dacbank_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd3;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [47:0] code_o;
    logic [7:0]  range_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [11:0] m_stage [4];
    logic [11:0] m_out   [4];
    logic [7:0]  m_range;
    logic        m_sync;

    always #2.5 clk = ~clk;

    dacbank_regs u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .code_o(code_o), .range_o(range_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_codes();
        return {m_out[3], m_out[2], m_out[1], m_out[0]};
    endfunction

    task automatic check_outs(input string tag);
        check({tag, " code_o"}, 64'(code_o), 64'(exp_codes()));
        check({tag, " range_o"}, 64'(range_o), 64'(m_range));
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'd3;
        if (a[0] == 1'b0 && a < 4'd8) begin
            m_stage[a >> 1] = d[11:0];
            if (!m_sync) m_out[a >> 1] = d[11:0];
        end
        if (a == 4'd8) m_range = d[7:0];
        if (a == 4'd9 && m_sync)
            for (int c = 0; c < 4; c++) m_out[c] = m_stage[c];
        if (a == 4'd15) m_sync = d[0];
    endtask

    task automatic check_rd(input string tag, input logic [3:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        check(tag, 64'(rdata), 64'(exp));
        addr = 4'd3;
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin m_stage[c] = 12'h800; m_out[c] = 12'h800; end
        m_range = 8'hAA;
        m_sync  = 1'b1;
        repeat (3) @(negedge clk);
        check_outs("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_outs("R1 after reset");
        check_rd("R1 sync bit", 4'd15, 16'h0001);
        check_rd("R1 range reg", 4'd8, 16'h00AA);
        for (int c = 0; c < 4; c++) check_rd("R1 staged code", 4'(2*c), 16'h0800);

        // synchronized mode: staged writes, then one strobe
        for (int k = 0; k < 6; k++) begin
            for (int c = 0; c < 4; c++) begin
                do_wr(4'(2*c), 16'((k*16'h3A5B) ^ (c*16'h1111) ^ 16'hF000));
                check_outs("R4 staged write holds outputs");
                check_rd("R2 staged readback", 4'(2*c), {4'h0, m_stage[c]});
            end
            do_wr(4'd9, 16'(k));
            check_outs("R4 strobe copies all");
        end

        // immediate mode
        do_wr(4'd15, 16'hFFFE);
        check_rd("R7 sync off readback", 4'd15, 16'h0000);
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 16; k++) begin
                do_wr(4'(2*c), 16'((k << 12) | ((k*12'h111 + c*12'h2F7) & 16'h0FFF)));
                check_outs("R3 immediate update");
                check_rd("R2 high bits dropped", 4'(2*c), {4'h0, m_stage[c]});
            end
        end
        do_wr(4'd0, 16'h0123);
        do_wr(4'd15, 16'h0001);
        do_wr(4'd0, 16'h0FED);
        do_wr(4'd15, 16'h0000);
        do_wr(4'd9, 16'hFFFF);
        check_outs("R5 strobe ignored in immediate mode");
        check_rd("R5 staged code still pending", 4'd0, 16'h0FED);

        // range sweep in both modes
        for (int m = 0; m < 2; m++) begin
            do_wr(4'd15, 16'(m));
            for (int v = 0; v < 256; v++) begin
                do_wr(4'd8, 16'(16'hA500 | v));
                check_outs("R6 range write");
            end
            check_rd("R6 range readback", 4'd8, {8'h00, m_range});
        end
        check("R6 channel 1 range code", 64'(range_o[3:2]), 64'(2'd3));

        // unused offsets, both modes
        for (int m = 0; m < 2; m++) begin
            do_wr(4'd15, 16'(m));
            for (int a = 0; a < 16; a++) begin
                if ((a[0] == 0 && a < 8) || a == 8 || a == 9 || a == 15) continue;
                do_wr(4'(a), 16'hFFFF);
                check_outs("R8 unused write");
                check_rd("R8 unused read", 4'(a), 16'h0000);
                check_rd("R8 mode untouched", 4'd15, 16'(m));
            end
        end
        check_rd("R7 final sync", 4'd15, 16'h0001);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule